// File: doc/BRIEF.md
# Ranged Interrupt Gathering Controller

This block collects interrupt lines in groups of 32 and turns them into one interrupt request output. The groups are called ranges. Each line has a detection mode of its own. A level-type line shows the current synchronized input. An edge-type line records a rising edge and keeps it until software clears it.

The captured bits pass through three gates in turn: a per-line enable, a global master enable, and finally an output enable that acts only on the physical request pin. Software reaches all of this through a plain 32-bit register bus. The bus has an address, a write strobe with write data, and a read strobe. Read data is returned one cycle after the read strobe.

Each range owns a window of eight word registers. These are the enable, separate set and clear aliases for the enable, the detection mode, the masked status, the raw captured status, a raw clear, and a software trigger that works only on edge-type lines.

Top module: `irq_gather_ctrl`

## Requirements
- R1: The word at byte offset 0x000 reads as the version (default 0x0102) in bits 31:16 and the number of lines (32 times the range count, 0x0040 by default) in bits 15:0. Writes to it are ignored.
- R2: After reset, every range reads zero in ENABLE, TYPE, RAW_STATUS and IRQ_STATUS. The output enable (offset 0x004, bit 0) and the master enable (offset 0x008, bit 0) both read 0, and irq_out is 0.
- R3: Range n places its registers at byte offset 0x010 + 0x20*n + 4*k, where k is 0 for ENABLE, 1 for ENABLE_CLEAR, 2 for ENABLE_SET, 3 for TYPE, 4 for IRQ_STATUS, 5 for RAW_STATUS, 6 for INT_CLEAR and 7 for SOFT_INT. A write to ENABLE loads all 32 bits. A 1 bit written to ENABLE_SET sets that enable bit, and a 1 bit written to ENABLE_CLEAR clears it. A 0 bit written to either alias leaves the enable bit unchanged.
- R4: A line whose TYPE bit is 0 is level type. Its RAW_STATUS bit follows the synchronized input. Writing 1 to its INT_CLEAR bit has no lasting effect while the input stays high.
- R5: A line whose TYPE bit is 1 is edge type. A rising edge of its synchronized input sets its RAW_STATUS bit. The bit stays set after the input falls, and writing 1 to its INT_CLEAR bit clears it.
- R6: An input change reaches the edge detector after SYNC_STAGES clock edges, and RAW_STATUS updates on the following edge. If a rising edge arrives in the same cycle as an INT_CLEAR write to that bit, the edge wins and the bit stays set.
- R7: Writing 1 to a SOFT_INT bit sets the matching RAW_STATUS bit only when that line is edge type. The write has no effect on level-type lines or for 0 bits.
- R8: IRQ_STATUS reads as RAW_STATUS AND ENABLE while the master enable is 1, and reads as zero while the master enable is 0.
- R9: Offset 0x00C reads, in bit 0, the OR of all IRQ_STATUS bits. irq_out equals that bit AND the output enable. The output enable changes no status register.
- R10: Read data is registered. It appears in the cycle after bus_re is high and holds while bus_re is low. Unmapped offsets, including the windows of ranges beyond NUM_BANKS, read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | NUM_BANKS*32 | Asynchronous interrupt lines; bit 32*n+i is line i of range n |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Interrupt request output |

## Verification
The bench builds the block with its defaults: two ranges, a two-stage synchronizer and a 12-bit address. With two ranges, the enable and status aggregation across more than one window is exercised, and the window of a third, absent range can be probed as unmapped space. The two-stage synchronizer gives a fixed latency. That fixed latency lets the bench line up an INT_CLEAR write with a fresh rising edge in the exact cycle needed to exercise the priority rule.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned LINES_PER_BANK = 32;
   localparam int unsigned REGS_PER_BANK  = 8;
   localparam int unsigned BANK_BASE      = 16;
   localparam int unsigned BANK_STRIDE    = 32;

   typedef enum logic [2:0] {
      RG_ENABLE   = 3'd0,
      RG_EN_CLR   = 3'd1,
      RG_EN_SET   = 3'd2,
      RG_TYPE     = 3'd3,
      RG_IRQ_STAT = 3'd4,
      RG_RAW_STAT = 3'd5,
      RG_RAW_CLR  = 3'd6,
      RG_SOFT     = 3'd7
   } bank_reg_e;

   typedef enum logic [1:0] {
      GR_IDENT  = 2'd0,
      GR_OUT_EN = 2'd1,
      GR_MASTER = 2'd2,
      GR_MSTAT  = 2'd3
   } glob_reg_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_out = async_in;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q <= '0;
            end else begin
               stage_q[0] <= async_in;
               for (int s = 1; s < int'(STAGES); s++) begin
                  stage_q[s] <= stage_q[s-1];
               end
            end
         end
         assign sync_out = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
   import irqc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [LINES_PER_BANK-1:0]     src_async,
   input  logic [REGS_PER_BANK-1:0]      wr_sel,
   input  logic [31:0]                   wdata,
   input  logic                          master_en,
   output logic [LINES_PER_BANK-1:0]     en_q,
   output logic [LINES_PER_BANK-1:0]     type_q,
   output logic [LINES_PER_BANK-1:0]     raw_q,
   output logic [LINES_PER_BANK-1:0]     stat_o
);
   localparam int unsigned W = LINES_PER_BANK;

   logic [W-1:0] det;
   logic [W-1:0] det_prev_q;
   logic [W-1:0] rise;
   logic [W-1:0] clr_v;
   logic [W-1:0] soft_v;
   logic [W-1:0] raw_d;

   irqc_sync #(.WIDTH(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (src_async),
      .sync_out (det)
   );

   assign rise   = det & ~det_prev_q;
   assign clr_v  = wr_sel[RG_RAW_CLR] ? wdata[W-1:0] : '0;
   assign soft_v = wr_sel[RG_SOFT]    ? wdata[W-1:0] : '0;

   // edge lines: new edge beats a clear in the same cycle
   assign raw_d = (type_q & ((raw_q & ~clr_v) | rise | soft_v))
                | (~type_q & det);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= '0;
         type_q     <= '0;
         raw_q      <= '0;
         det_prev_q <= '0;
      end else begin
         det_prev_q <= det;
         raw_q      <= raw_d;
         if (wr_sel[RG_ENABLE]) begin
            en_q <= wdata[W-1:0];
         end else if (wr_sel[RG_EN_SET]) begin
            en_q <= en_q | wdata[W-1:0];
         end else if (wr_sel[RG_EN_CLR]) begin
            en_q <= en_q & ~wdata[W-1:0];
         end
         if (wr_sel[RG_TYPE]) begin
            type_q <= wdata[W-1:0];
         end
      end
   end

   assign stat_o = raw_q & en_q & {W{master_en}};

   p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(rise & clr_v & type_q) & ~raw_q) == '0));

   p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(det) ^ raw_q) & ~$past(type_q)) == '0));

   p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[RG_EN_SET] |=> (($past(wdata[W-1:0]) & ~en_q) == '0));
endmodule

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 12,
   parameter logic [15:0] VERSION     = 16'h0102
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_BANKS*LINES_PER_BANK-1:0] irq_src,
   input  logic [ADDR_W-1:0]                   bus_addr,
   input  logic                                bus_we,
   input  logic [31:0]                         bus_wdata,
   input  logic                                bus_re,
   output logic [31:0]                         bus_rdata,
   output logic                                irq_out
);
   localparam int unsigned NUM_LINES = NUM_BANKS * LINES_PER_BANK;
   localparam logic [15:0] LINE_CNT  = 16'(NUM_LINES);

   generate
      if (NUM_BANKS < 1 || NUM_BANKS > 8) begin : g_bad_banks
         $error("NUM_BANKS must lie in 1..8");
      end
      if (ADDR_W < 9) begin : g_bad_addr
         $error("ADDR_W must be at least 9");
      end
      if (VERSION < 16'h0102) begin : g_bad_ver
         $error("VERSION below minimum");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must not exceed 4");
      end
   endgenerate

   // decode
   logic [ADDR_W-1:0] rel;
   logic              is_glob;
   logic              in_bank_win;
   logic [2:0]        bank_idx;
   logic [2:0]        reg_idx;
   logic [1:0]        glob_idx;

   assign is_glob     = (bus_addr < ADDR_W'(BANK_BASE));
   assign rel         = bus_addr - ADDR_W'(BANK_BASE);
   assign in_bank_win = !is_glob && (rel[ADDR_W-1:8] == '0);
   assign bank_idx    = rel[7:5];
   assign reg_idx     = rel[4:2];
   assign glob_idx    = bus_addr[3:2];

   // global registers
   logic out_en_q;
   logic master_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_en_q <= 1'b0;
         master_q <= 1'b0;
      end else if (bus_we && is_glob) begin
         if (glob_idx == GR_OUT_EN) out_en_q <= bus_wdata[0];
         if (glob_idx == GR_MASTER) master_q <= bus_wdata[0];
      end
   end

   // ranges
   logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] en_a;
   logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] type_a;
   logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] raw_a;
   logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] stat_a;

   generate
      for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
         logic                     hit;
         logic [REGS_PER_BANK-1:0] sel;
         assign hit = bus_we && in_bank_win && (bank_idx == 3'(b));
         assign sel = hit ? (REGS_PER_BANK'(1) << reg_idx) : '0;
         irqc_bank #(.SYNC_STAGES(SYNC_STAGES)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_async (irq_src[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .wr_sel    (sel),
            .wdata     (bus_wdata),
            .master_en (master_q),
            .en_q      (en_a[b]),
            .type_q    (type_a[b]),
            .raw_q     (raw_a[b]),
            .stat_o    (stat_a[b])
         );
      end
   endgenerate

   logic master_stat;
   assign master_stat = |stat_a;
   assign irq_out     = master_stat & out_en_q;

   // read mux
   logic [31:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (is_glob) begin
         case (glob_idx)
            GR_IDENT:  rd_mux = {VERSION, LINE_CNT};
            GR_OUT_EN: rd_mux = {31'd0, out_en_q};
            GR_MASTER: rd_mux = {31'd0, master_q};
            default:   rd_mux = {31'd0, master_stat};
         endcase
      end else if (in_bank_win) begin
         for (int b = 0; b < int'(NUM_BANKS); b++) begin
            if (bank_idx == 3'(b)) begin
               case (reg_idx)
                  RG_ENABLE:   rd_mux = en_a[b];
                  RG_TYPE:     rd_mux = type_a[b];
                  RG_IRQ_STAT: rd_mux = stat_a[b];
                  RG_RAW_STAT: rd_mux = raw_a[b];
                  default:     rd_mux = '0;
               endcase
            end
         end
      end
   end

   logic [31:0] rdata_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_re) rdata_q <= rd_mux;
   end
   assign bus_rdata = rdata_q;

   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> $stable(bus_rdata));

   p_master_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !master_q |-> (stat_a == '0));
endmodule

// File: tb/irq_gather_ctrl_tb_top.sv
module irq_gather_ctrl_tb_top;
   localparam int NB = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB*32-1:0] irq_src = '0;
   logic [11:0]   bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_re = 1'b0;
   logic [31:0]   bus_rdata;
   logic          irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_gather_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
      .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   function automatic logic [11:0] badr(int b, int k);
      return 12'(16 + 32*b + 4*k);
   endfunction

   function automatic logic [31:0] exp_stat(logic [31:0] raw, logic [31:0] en, logic m);
      return m ? (raw & en) : 32'd0;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (6) @(posedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d, hold;
      logic [31:0] en_m [NB];
      logic [31:0] ty_m [NB];
      logic [31:0] raw_m [NB];
      logic [NB*32-1:0] s;
      logic master, oen, any;
      void'($urandom(32'h1234abcd));

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R2 reset state
      for (int b = 0; b < NB; b++) begin
         rd(badr(b, 0), d); chk("R2 enable", d, 0);
         rd(badr(b, 3), d); chk("R2 type", d, 0);
         rd(badr(b, 5), d); chk("R2 raw", d, 0);
         rd(badr(b, 4), d); chk("R2 irqstat", d, 0);
      end
      rd(12'h004, d); chk("R2 out_en", d, 0);
      rd(12'h008, d); chk("R2 master", d, 0);
      chk("R2 irq_out", {31'd0, irq_out}, 0);

      // R1 identity
      rd(12'h000, d); chk("R1 ident", d, 32'h0102_0040);
      wr(12'h000, 32'hFFFF_FFFF);
      rd(12'h000, d); chk("R1 ident after write", d, 32'h0102_0040);

      // R10 unmapped and hold
      rd(badr(2, 0), d); chk("R10 absent range", d, 0);
      rd(12'h1F0, d); chk("R10 unmapped", d, 0);
      rd(12'h000, hold);
      @(negedge clk) bus_addr = badr(0, 5);
      repeat (3) @(posedge clk);
      @(negedge clk) chk("R10 hold", bus_rdata, hold);

      // R3 enable aliases
      wr(badr(1, 0), 32'h0000_00F0);
      wr(badr(1, 2), 32'h0000_0003);
      rd(badr(1, 0), d); chk("R3 set", d, 32'h0000_00F3);
      wr(badr(1, 1), 32'h0000_0030);
      rd(badr(1, 0), d); chk("R3 clear", d, 32'h0000_00C3);
      wr(badr(1, 2), 32'h0);
      wr(badr(1, 1), 32'h0);
      rd(badr(1, 0), d); chk("R3 zero writes", d, 32'h0000_00C3);
      wr(badr(1, 0), 32'h0);

      // R4 level line: bank1 bit5
      irq_src[32+5] = 1'b1; settle();
      rd(badr(1, 5), d); chk("R4 level high", d, 32'h20);
      wr(badr(1, 6), 32'h20); settle();
      rd(badr(1, 5), d); chk("R4 clear no effect", d, 32'h20);
      irq_src[32+5] = 1'b0; settle();
      rd(badr(1, 5), d); chk("R4 level low", d, 0);
      // R7 soft on level line
      wr(badr(1, 7), 32'h20);
      rd(badr(1, 5), d); chk("R7 soft level ignored", d, 0);

      // R5 edge line: bank0 bit0
      wr(badr(0, 3), 32'h1);
      irq_src[0] = 1'b1; settle();
      irq_src[0] = 1'b0; settle();
      rd(badr(0, 5), d); chk("R5 edge held", d, 32'h1);
      wr(badr(0, 6), 32'h1);
      rd(badr(0, 5), d); chk("R5 edge cleared", d, 0);
      // R7 soft on edge line
      wr(badr(0, 7), 32'h3);
      rd(badr(0, 5), d); chk("R7 soft edge", d, 32'h1);

      // R6 edge in same cycle as clear (raw bit0 already set)
      @(negedge clk) irq_src[0] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_addr = badr(0, 6); bus_wdata = 32'h1; bus_we = 1'b1;
      @(posedge clk);
      @(negedge clk) bus_we = 1'b0;
      rd(badr(0, 5), d); chk("R6 edge wins", d, 32'h1);
      irq_src[0] = 1'b0; settle();
      wr(badr(0, 6), 32'h1);
      wr(badr(0, 3), 32'h0);

      // R8/R9 directed gating
      wr(badr(0, 3), 32'h1);
      wr(badr(0, 7), 32'h1);
      wr(badr(0, 0), 32'h1);
      rd(badr(0, 4), d); chk("R8 master off", d, 0);
      wr(12'h008, 32'h1);
      rd(badr(0, 4), d); chk("R8 master on", d, 32'h1);
      rd(12'h00C, d); chk("R9 master status", d, 32'h1);
      chk("R9 irq_out gated off", {31'd0, irq_out}, 0);
      wr(12'h004, 32'h1);
      @(negedge clk) chk("R9 irq_out on", {31'd0, irq_out}, 1);
      rd(badr(0, 4), d); chk("R9 status unaffected", d, 32'h1);
      wr(badr(0, 6), 32'h1);
      @(negedge clk) chk("R9 irq_out drops", {31'd0, irq_out}, 0);

      // random phase
      for (int it = 0; it < 12; it++) begin
         master = 1'($urandom);
         oen    = 1'($urandom);
         wr(12'h008, {31'd0, master});
         wr(12'h004, {31'd0, oen});
         irq_src = '0; settle();
         for (int b = 0; b < NB; b++) begin
            en_m[b] = $urandom; ty_m[b] = $urandom;
            wr(badr(b, 0), en_m[b]);
            wr(badr(b, 3), ty_m[b]);
            wr(badr(b, 6), 32'hFFFF_FFFF);
         end
         s = {$urandom, $urandom};
         irq_src = s; settle();
         any = 1'b0;
         for (int b = 0; b < NB; b++) begin
            raw_m[b] = s[b*32 +: 32];
            rd(badr(b, 5), d); chk("R5 random raw", d, raw_m[b]);
            rd(badr(b, 4), d); chk("R8 random stat", d, exp_stat(raw_m[b], en_m[b], master));
            any = any | (|exp_stat(raw_m[b], en_m[b], master));
         end
         rd(12'h00C, d); chk("R9 random mstat", d, {31'd0, any});
         chk("R9 random irq_out", {31'd0, irq_out}, {31'd0, any & oen});
         irq_src = '0; settle();
         for (int b = 0; b < NB; b++) begin
            raw_m[b] = raw_m[b] & ty_m[b];
            rd(badr(b, 5), d); chk("R4 random after fall", d, raw_m[b]);
            d = $urandom;
            wr(badr(b, 7), d);
            raw_m[b] = raw_m[b] | (d & ty_m[b]);
            rd(badr(b, 5), d); chk("R7 random soft", d, raw_m[b]);
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule